// File: doc/BRIEF.md
# Address Region Steering Unit

This block sits in a processor's address path and decides, for every memory or I/O request, which downstream resource serves it: SDRAM, the flash device, PCI, or the general-purpose peripheral bus. Sixteen programmable region words each describe one window of the address space. A region word holds a base, a page count, a page size of 4KB or 64KB, a region kind that names both the request class (memory or I/O) and the destination, a write-protect flag and a cache-disable flag. The unit reports the destination, whether a write was refused, whether the access may be cached, and which region matched. Each response appears on the clock edge after its request.

The region words and a window-location word are reached through a 4KB configuration window that lives in the memory space. After reset the window sits at 0xFFFEF000. Software can open a second copy of the window at any 4KB-aligned location below 1GB. The default copy never goes away. A memory request that lands in either copy is a register access. It takes priority over every region, and read data comes back on the response.

After reset, the last region word covers the legacy ROM range 0xE0000 to 0xFFFFF and sends it to SDRAM. All other regions start disabled.

Top module: `addr_steer_unit`

## Requirements
- R1: After reset, regions 0 to 14 read 0x00000000 and region 15 reads 0xC007C0E0. Memory requests from 0xE0000 through 0xFFFFF are sent to SDRAM through region 15. Memory requests at 0xDFFFF and at 0x100000 go to PCI.
- R2: Every request produces exactly one response on the next clock edge: rsp_valid equals req_valid delayed by one cycle. While rsp_valid is low, all other outputs are 0.
- R3: A region word is laid out as follows. Bits 31:29 hold the kind. Bit 28 is stored but has no effect. Bit 27 is cache-disable, bit 26 is write-protect and bit 25 selects 64KB pages. Bits 24:14 hold the page count minus one, and bits 13:0 hold the base page number. A written word reads back unchanged.
- R4: A region covers page numbers base through base+count, inclusive. The page number is address[31:12] for 4KB pages and address[31:16] for 64KB pages. For I/O requests, address bits 31:16 are treated as zero.
- R5: Kind encodings: 0 and 7 never match. Kind 1 routes I/O to the general-purpose bus and kind 2 routes I/O to PCI. Kind 3 routes memory to the general-purpose bus, 4 to flash, 5 to PCI and 6 to SDRAM. An I/O kind matches only I/O requests, and a memory kind matches only memory requests. rsp_dest codes are: SDRAM 0, flash 1, PCI 2, general-purpose bus 3, configuration window 4.
- R6: When several regions match a request, the lowest-numbered one wins. rsp_region_hit is set and rsp_region carries that region's index.
- R7: A request that matches no region and no window goes to PCI, with rsp_region_hit, rsp_region, rsp_wr_blocked and rsp_cacheable all 0.
- R8: A write that hits a write-protected region raises rsp_wr_blocked. Reads are never blocked.
- R9: rsp_cacheable is 1 only for a memory request that hits a memory region whose cache-disable bit is clear. I/O requests are never cacheable.
- R10: A memory request whose address[31:12] equals 0xFFFEF hits the configuration window and is reported with rsp_dest 4. It takes priority over every region, and its region, blocked and cacheable outputs are 0. Word offset 4*i selects region word i, and offset 0x40 selects the window-location word. A write changes the word in time for the next request. A read returns the word on rsp_rdata. Offsets that are unmapped or not word-aligned read 0 and ignore writes. rsp_rdata is 0 for every response that is not a window read.
- R11: The window-location word keeps bits 29:12, the location, and bit 0, the enable. All other bits read 0. While it is enabled, the window also answers for memory requests whose address[31:30] is 0 and whose address[29:12] equals the location. The default window keeps answering.
- R12: I/O requests never hit the configuration window, whatever their address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_io | input | 1 | 1 for an I/O request, 0 for a memory request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 32 | Request byte address |
| req_wdata | input | 32 | Write data for configuration-window writes |
| rsp_valid | output | 1 | Response present |
| rsp_dest | output | 3 | Destination code |
| rsp_region_hit | output | 1 | A region matched |
| rsp_region | output | 4 | Index of the winning region |
| rsp_wr_blocked | output | 1 | Write refused by write protection |
| rsp_cacheable | output | 1 | Access may be cached |
| rsp_rdata | output | 32 | Configuration-window read data |

## Verification
The bench goes after these corner cases:
- **Inclusive region ends.** The first and last page of each region, and one page beyond each end, in both page sizes. An off-by-one in the count field would move a boundary by one page.
- **Overlaps and disabled kinds.** Overlapping regions must resolve to the lower index. Regions of kind 0 and 7 lie across an enabled higher-numbered region and must never win. A priority encoder that scans the wrong way, or treats 7 as valid, would report the wrong region.
- **Address-space separation.** I/O requests carry junk in their upper address bits, and some of them carry the window's address. A design that compares the full address for I/O, or lets I/O reach the window, would steer them wrongly.
- **Window relocation and protection.** The window is moved, written through its new copy, read back through the default copy, and then disabled. Writes to unaligned and unmapped offsets are made, and the region words are then read back to show that nothing changed. Write protection is tested for both reads and writes.

A long pseudo-random sweep compares every response field against an arithmetic model.

// File: rtl/steer_pkg.sv
package steer_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned WIN_WORD_W = 10;
    localparam int unsigned CBASE_WORD = 16;

    typedef enum logic [2:0] {
        KIND_OFF       = 3'd0,
        KIND_IO_GP     = 3'd1,
        KIND_IO_PCI    = 3'd2,
        KIND_MEM_GP    = 3'd3,
        KIND_MEM_FLASH = 3'd4,
        KIND_MEM_PCI   = 3'd5,
        KIND_MEM_SDRAM = 3'd6,
        KIND_RSVD      = 3'd7
    } steer_kind_e;

    typedef enum logic [2:0] {
        DEST_SDRAM = 3'd0,
        DEST_FLASH = 3'd1,
        DEST_PCI   = 3'd2,
        DEST_GP    = 3'd3,
        DEST_CFG   = 3'd4
    } steer_dest_e;

    typedef struct packed {
        steer_kind_e  kind;
        logic         spare;
        logic         no_cache;
        logic         wr_prot;
        logic         big_page;
        logic [10:0]  pages_m1;
        logic [13:0]  base;
    } region_word_t;

    typedef struct packed {
        steer_dest_e dest;
        logic        hit;
        logic        blocked;
        logic        cacheable;
    } steer_result_t;

    function automatic logic kind_active(steer_kind_e k);
        return (k != KIND_OFF) && (k != KIND_RSVD);
    endfunction

    function automatic logic kind_is_io(steer_kind_e k);
        return (k == KIND_IO_GP) || (k == KIND_IO_PCI);
    endfunction

    function automatic steer_dest_e kind_to_dest(steer_kind_e k);
        case (k)
            KIND_IO_GP, KIND_MEM_GP: return DEST_GP;
            KIND_MEM_FLASH:          return DEST_FLASH;
            KIND_MEM_SDRAM:          return DEST_SDRAM;
            default:                 return DEST_PCI;
        endcase
    endfunction

    function automatic logic region_covers(region_word_t w, logic [31:0] addr, logic is_io);
        logic [31:0] eff;
        logic [20:0] page;
        logic [20:0] first;
        logic [20:0] last;
        eff   = is_io ? {16'h0000, addr[15:0]} : addr;
        page  = w.big_page ? {5'd0, eff[31:16]} : {1'b0, eff[31:12]};
        first = {7'd0, w.base};
        last  = first + {10'd0, w.pages_m1};
        return kind_active(w.kind) && (kind_is_io(w.kind) == is_io) &&
               (page >= first) && (page <= last);
    endfunction

    function automatic region_word_t legacy_rom_word();
        region_word_t w;
        w          = '0;
        w.kind     = KIND_MEM_SDRAM;
        w.base     = 14'h00E0;
        w.pages_m1 = 11'h01F;
        return w;
    endfunction

endpackage

// File: rtl/steer_region_file.sv
module steer_region_file
    import steer_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 16,
    parameter int unsigned ROM_IDX     = 15
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr_en,
    input  logic [WIN_WORD_W-1:0]               wr_word,
    input  logic [WORD_W-1:0]                   wr_data,
    input  logic [WIN_WORD_W-1:0]               rd_word,
    output region_word_t [NUM_REGIONS-1:0]      regs,
    output logic [17:0]                         win_loc,
    output logic                                win_en,
    output logic [WORD_W-1:0]                   rd_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(NUM_REGIONS); i++) begin
                regs[i] <= (i == int'(ROM_IDX)) ? legacy_rom_word() : '0;
            end
            win_loc <= '0;
            win_en  <= 1'b0;
        end else if (wr_en) begin
            for (int i = 0; i < int'(NUM_REGIONS); i++) begin
                if (wr_word == WIN_WORD_W'(i)) begin
                    regs[i] <= region_word_t'(wr_data);
                end
            end
            if (wr_word == WIN_WORD_W'(CBASE_WORD)) begin
                win_loc <= wr_data[29:12];
                win_en  <= wr_data[0];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < int'(NUM_REGIONS); i++) begin
            if (rd_word == WIN_WORD_W'(i)) begin
                rd_data = regs[i];
            end
        end
        if (rd_word == WIN_WORD_W'(CBASE_WORD)) begin
            rd_data = {2'b00, win_loc, 11'd0, win_en};
        end
    end

endmodule

// File: rtl/steer_region_match.sv
module steer_region_match
    import steer_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 16
) (
    input  region_word_t [NUM_REGIONS-1:0] regs,
    input  logic [31:0]                    addr,
    input  logic                           is_io,
    output logic [NUM_REGIONS-1:0]         hits
);

    for (genvar g = 0; g < int'(NUM_REGIONS); g++) begin : g_cmp
        assign hits[g] = region_covers(regs[g], addr, is_io);
    end

endmodule

// File: rtl/steer_priority_pick.sv
module steer_priority_pick #(
    parameter int unsigned NUM_REGIONS = 16,
    parameter int unsigned IDX_W       = 4
) (
    input  logic [NUM_REGIONS-1:0] hits,
    output logic                   found,
    output logic [IDX_W-1:0]       idx
);

    always_comb begin
        found = |hits;
        idx   = '0;
        for (int i = int'(NUM_REGIONS) - 1; i >= 0; i--) begin
            if (hits[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/addr_steer_unit.sv
module addr_steer_unit
    import steer_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 16,
    parameter int unsigned ROM_IDX     = 15,
    parameter logic [31:0] WIN_DEFAULT = 32'hFFFE_F000,
    localparam int unsigned IDX_W      = $clog2(NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_io,
    input  logic              req_write,
    input  logic [31:0]       req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [2:0]        rsp_dest,
    output logic              rsp_region_hit,
    output logic [IDX_W-1:0]  rsp_region,
    output logic              rsp_wr_blocked,
    output logic              rsp_cacheable,
    output logic [31:0]       rsp_rdata
);

    region_word_t [NUM_REGIONS-1:0] regs;
    logic [17:0]             win_loc;
    logic                    win_en;
    logic [WORD_W-1:0]       rd_data;
    logic [NUM_REGIONS-1:0]  hits;
    logic                    found;
    logic [IDX_W-1:0]        pick_idx;

    // Configuration-window decode
    logic                    aligned;
    logic                    def_hit;
    logic                    alias_hit;
    logic                    cfg_hit;
    logic [WIN_WORD_W-1:0]   win_word;
    logic                    cfg_wr;

    assign aligned   = (req_addr[1:0] == 2'b00);
    assign def_hit   = !req_io && (req_addr[31:12] == WIN_DEFAULT[31:12]);
    assign alias_hit = !req_io && win_en && (req_addr[31:30] == 2'b00) &&
                       (req_addr[29:12] == win_loc);
    assign cfg_hit   = def_hit || alias_hit;
    assign win_word  = aligned ? req_addr[11:2] : '1;
    assign cfg_wr    = req_valid && req_write && cfg_hit && aligned;

    steer_region_file #(
        .NUM_REGIONS (NUM_REGIONS),
        .ROM_IDX     (ROM_IDX)
    ) u_file (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .wr_word (win_word),
        .wr_data (req_wdata),
        .rd_word (win_word),
        .regs    (regs),
        .win_loc (win_loc),
        .win_en  (win_en),
        .rd_data (rd_data)
    );

    steer_region_match #(
        .NUM_REGIONS (NUM_REGIONS)
    ) u_match (
        .regs  (regs),
        .addr  (req_addr),
        .is_io (req_io),
        .hits  (hits)
    );

    steer_priority_pick #(
        .NUM_REGIONS (NUM_REGIONS),
        .IDX_W       (IDX_W)
    ) u_pick (
        .hits  (hits),
        .found (found),
        .idx   (pick_idx)
    );

    // Attribute selection for the winning region
    region_word_t  win_word_sel;
    steer_result_t nxt;

    assign win_word_sel = regs[pick_idx];

    always_comb begin
        nxt = '0;
        if (cfg_hit) begin
            nxt.dest = DEST_CFG;
        end else if (found) begin
            nxt.dest      = kind_to_dest(win_word_sel.kind);
            nxt.hit       = 1'b1;
            nxt.blocked   = req_write && win_word_sel.wr_prot;
            nxt.cacheable = !req_io && !win_word_sel.no_cache;
        end else begin
            nxt.dest = DEST_PCI;
        end
    end

    // Response register
    steer_result_t      res_q;
    logic               valid_q;
    logic [IDX_W-1:0]   region_q;
    logic [31:0]        rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            res_q    <= '0;
            region_q <= '0;
            rdata_q  <= '0;
        end else begin
            valid_q  <= req_valid;
            res_q    <= req_valid ? nxt : '0;
            region_q <= (req_valid && !cfg_hit && found) ? pick_idx : '0;
            rdata_q  <= (req_valid && cfg_hit && !req_write) ? rd_data : '0;
        end
    end

    assign rsp_valid      = valid_q;
    assign rsp_dest       = res_q.dest;
    assign rsp_region_hit = res_q.hit;
    assign rsp_region     = region_q;
    assign rsp_wr_blocked = res_q.blocked;
    assign rsp_cacheable  = res_q.cacheable;
    assign rsp_rdata      = rdata_q;

endmodule

// File: rtl/steer_chk.sv
module steer_chk #(
    parameter logic [31:0] WIN_DEFAULT = 32'hFFFE_F000
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_io,
    input logic        req_write,
    input logic [31:0] req_addr,
    input logic        rsp_valid,
    input logic [2:0]  rsp_dest,
    input logic        rsp_region_hit,
    input logic        rsp_wr_blocked,
    input logic        rsp_cacheable
);

    // R2
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R10
    win_default_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_io && req_addr[31:12] == WIN_DEFAULT[31:12]) |=> (rsp_dest == 3'd4));

    // R10
    win_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_dest == 3'd4) |-> (!rsp_region_hit && !rsp_wr_blocked && !rsp_cacheable));

    // R12
    io_route_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_io) |=> (rsp_dest == 3'd2 || rsp_dest == 3'd3));

    // R7
    miss_pci_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_region_hit && rsp_dest != 3'd4) |-> (rsp_dest == 3'd2 && !rsp_cacheable));

    // R8
    block_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_wr_blocked |-> rsp_region_hit);

    // R8
    read_unblocked_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> !rsp_wr_blocked);

    // R9
    io_nocache_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_io) |=> !rsp_cacheable);

endmodule

bind addr_steer_unit steer_chk #(
    .WIN_DEFAULT (WIN_DEFAULT)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_io         (req_io),
    .req_write      (req_write),
    .req_addr       (req_addr),
    .rsp_valid      (rsp_valid),
    .rsp_dest       (rsp_dest),
    .rsp_region_hit (rsp_region_hit),
    .rsp_wr_blocked (rsp_wr_blocked),
    .rsp_cacheable  (rsp_cacheable)
);

// File: tb/sim_addr_steer_unit.sv
module sim_addr_steer_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_io, req_write;
    logic [31:0] req_addr, req_wdata;
    logic        rsp_valid, rsp_region_hit, rsp_wr_blocked, rsp_cacheable;
    logic [2:0]  rsp_dest;
    logic [3:0]  rsp_region;
    logic [31:0] rsp_rdata;

    always #4 clk = ~clk;

    addr_steer_unit u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_io(req_io),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_dest(rsp_dest), .rsp_region_hit(rsp_region_hit),
        .rsp_region(rsp_region), .rsp_wr_blocked(rsp_wr_blocked),
        .rsp_cacheable(rsp_cacheable), .rsp_rdata(rsp_rdata)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [31:0] m_reg [16];
    logic [31:0] m_win;
    logic [2:0]  o_dest;
    logic        o_hit, o_blk, o_cach;
    logic [3:0]  o_reg;
    logic [31:0] o_rd;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit m_cover(logic [31:0] w, bit io, logic [31:0] a);
        int unsigned kind, page, first, last;
        logic [31:0] eff;
        kind = w[31:29];
        if (kind == 0 || kind == 7) return 0;
        if ((kind <= 2) != io) return 0;
        eff   = io ? (a & 32'h0000FFFF) : a;
        page  = w[25] ? eff / 65536 : eff / 4096;
        first = w[13:0];
        last  = first + w[24:14];
        return (page >= first) && (page <= last);
    endfunction

    function automatic logic [2:0] m_dest(int unsigned kind);
        case (kind)
            1, 3: return 3'd3;
            4:    return 3'd1;
            6:    return 3'd0;
            default: return 3'd2;
        endcase
    endfunction

    task automatic access(bit io, bit wr, logic [31:0] a, logic [31:0] d, string req);
        logic [2:0]  e_dest;
        logic        e_hit, e_blk, e_cach, cfg;
        logic [3:0]  e_reg;
        logic [31:0] e_rd;
        int          widx;
        cfg = !io && ((a[31:12] == 20'hFFFEF) ||
                      (m_win[0] && a[31:30] == 2'b00 && a[29:12] == m_win[29:12]));
        e_dest = 3'd2; e_hit = 0; e_blk = 0; e_cach = 0; e_reg = 0; e_rd = 0;
        widx = a[11:2];
        if (cfg) begin
            e_dest = 3'd4;
            if (!wr && a[1:0] == 2'b00) begin
                if (widx < 16) e_rd = m_reg[widx];
                else if (widx == 16) e_rd = m_win;
            end
        end else begin
            for (int i = 15; i >= 0; i--) begin
                if (m_cover(m_reg[i], io, a)) begin
                    e_hit  = 1;
                    e_reg  = 4'(i);
                    e_dest = m_dest(m_reg[i][31:29]);
                    e_blk  = wr && m_reg[i][26];
                    e_cach = !io && !m_reg[i][27];
                end
            end
        end
        @(negedge clk);
        req_valid = 1; req_io = io; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        o_dest = rsp_dest; o_hit = rsp_region_hit; o_reg = rsp_region;
        o_blk = rsp_wr_blocked; o_cach = rsp_cacheable; o_rd = rsp_rdata;
        check(req, {21'd0, rsp_valid, rsp_dest, rsp_region_hit, rsp_region, rsp_wr_blocked, rsp_cacheable},
              {21'd0, 1'b1, e_dest, e_hit, e_reg, e_blk, e_cach},
              $sformatf("resp io=%0d wr=%0d addr=%h {v,dest,hit,reg,blk,cach}", io, wr, a));
        check(req, rsp_rdata, e_rd, $sformatf("rdata addr=%h", a));
        req_valid = 0;
        if (cfg && wr && a[1:0] == 2'b00) begin
            if (widx < 16) m_reg[widx] = d;
            else if (widx == 16) m_win = d & 32'h3FFFF001;
        end
    endtask

    task automatic cfg_wr(int idx, logic [31:0] d, string req);
        access(0, 1, 32'hFFFEF000 + 32'(idx * 4), d, req);
    endtask

    task automatic cfg_rd(int idx, string req);
        access(0, 0, 32'hFFFEF000 + 32'(idx * 4), 32'h0, req);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] lf;
        for (int i = 0; i < 16; i++) m_reg[i] = 32'h0;
        m_reg[15] = 32'hC007C0E0;
        m_win = 32'h0;
        req_valid = 0; req_io = 0; req_write = 0; req_addr = 0; req_wdata = 0;
        rst = 1;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R2: idle after reset
        check("R2", {28'd0, rsp_valid, rsp_dest}, 32'h0, "reset outputs");

        // R1 / R11: reset contents
        for (int i = 0; i < 17; i++) cfg_rd(i, "R1");
        check("R1", o_rd, 32'h0, "window word after reset R11");
        cfg_rd(15, "R1");
        check("R1", o_rd, 32'hC007C0E0, "legacy region word");
        access(0, 0, 32'h000DFFFF, 0, "R1");
        check("R1", {29'd0, o_dest}, 32'd2, "below legacy");
        access(0, 0, 32'h000E0000, 0, "R1");
        check("R1", {24'd0, o_hit, o_reg, o_dest}, {24'd0, 1'b1, 4'd15, 3'd0}, "legacy start");
        access(0, 0, 32'h000FFFFF, 0, "R1");
        check("R1", {29'd0, o_dest}, 32'd0, "legacy end");
        access(0, 0, 32'h00100000, 0, "R1");
        check("R1", {29'd0, o_dest}, 32'd2, "above legacy");

        // R3: program regions and read them back
        cfg_wr(0, 32'h8601C200, "R3");
        cfg_wr(1, 32'hC0FFC000, "R3");
        cfg_wr(2, 32'hA807C3F0, "R3");
        cfg_wr(3, 32'h68001000, "R3");
        cfg_wr(4, 32'h20000000, "R3");
        cfg_wr(5, 32'h44004001, "R3");
        cfg_wr(6, 32'hE0041800, "R3");
        cfg_wr(7, 32'h00041800, "R3");
        cfg_wr(8, 32'hD0001808, "R3");
        for (int i = 0; i < 16; i++) cfg_rd(i, "R3");

        // R4: 64KB flash region boundaries
        access(0, 0, 32'h01FFFFFF, 0, "R4");
        access(0, 0, 32'h02000000, 0, "R4");
        check("R4", {29'd0, o_dest}, 32'd1, "flash start dest");
        access(0, 0, 32'h0207FFFF, 0, "R4");
        access(0, 0, 32'h02080000, 0, "R4");
        check("R4", {29'd0, o_dest}, 32'd2, "past flash end");
        access(0, 0, 32'h01000000, 0, "R4");
        access(0, 0, 32'h01001000, 0, "R4");

        // R6: overlaps
        access(0, 0, 32'h000E0000, 0, "R6");
        check("R6", {28'd0, o_reg}, 32'd1, "region 1 beats 15");
        access(0, 0, 32'h003F8000, 0, "R6");
        check("R6", {28'd0, o_reg}, 32'd1, "region 1 beats 2");
        access(0, 0, 32'h00400000, 0, "R9");
        check("R9", {31'd0, o_cach}, 32'd0, "no-cache region");

        // R5: disabled kinds
        access(0, 0, 32'h01800000, 0, "R5");
        check("R5", {29'd0, o_dest}, 32'd2, "kind 7 and 0 ignored");
        access(0, 0, 32'h01808000, 0, "R5");
        check("R5", {28'd0, o_reg}, 32'd8, "region 8 behind disabled ones");

        // R8: write protection
        access(0, 1, 32'h02000100, 32'h5A5A5A5A, "R8");
        check("R8", {31'd0, o_blk}, 32'd1, "write to protected flash");
        access(0, 0, 32'h02000100, 0, "R8");
        check("R8", {31'd0, o_blk}, 32'd0, "read of protected flash");
        access(1, 1, 32'h00001800, 0, "R8");
        access(1, 0, 32'hABCD0800, 0, "R9");
        check("R9", {31'd0, o_cach}, 32'd0, "io never cacheable");

        // R12: I/O at window address
        access(1, 0, 32'hFFFEF000, 0, "R12");
        check("R12", {29'd0, o_dest}, 32'd2, "io not window");
        access(1, 1, 32'hFFFEF004, 32'hFFFFFFFF, "R12");
        cfg_rd(1, "R12");

        // R10: unaligned and unmapped offsets
        access(0, 1, 32'hFFFEF002, 32'h12345678, "R10");
        access(0, 0, 32'hFFFEF001, 0, "R10");
        check("R10", o_rd, 32'h0, "unaligned read");
        access(0, 1, 32'hFFFEF080, 32'h12345678, "R10");
        access(0, 0, 32'hFFFEF080, 0, "R10");
        access(0, 0, 32'hFFFEF044, 0, "R10");
        for (int i = 0; i < 16; i++) cfg_rd(i, "R10");

        // R11: relocation
        cfg_wr(16, 32'hC0123FFF, "R11");
        cfg_rd(16, "R11");
        check("R11", o_rd, 32'h00123001, "window word masked");
        access(0, 0, 32'h00123000, 0, "R11");
        check("R11", o_rd, 32'h8601C200, "read through alias");
        access(0, 1, 32'h00123024, 32'h6800F000, "R11");
        cfg_rd(9, "R11");
        check("R11", o_rd, 32'h6800F000, "alias write via default");
        access(0, 0, 32'h40123000, 0, "R11");
        cfg_wr(16, 32'h00000000, "R11");
        access(0, 0, 32'h00123000, 0, "R11");
        check("R11", {29'd0, o_dest}, 32'd0, "alias disabled");

        // Pseudo-random sweep
        lf = 32'h1ACE_B00C;
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] a;
            bit io;
            lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
            io = 0;
            case (n % 4)
                0: a = lf & 32'h03FFFFFF;
                1: a = 32'h02000000 | (lf & 32'h000FFFFF);
                2: begin a = lf; io = 1; end
                default: a = 32'h000C0000 + (lf & 32'h0007FFFF);
            endcase
            access(io, lf[31], a, 32'h0, "R4");
        end

        done = 1;
        finish_run();
    end

endmodule